// File: doc/BRIEF.md
# Speculative Fetch Front End with Epoch-Based Redirect

This block is the front half of a two-stage fetch/execute pipeline. Every cycle in which the fetch queue has room and instruction memory accepts a request, fetch sends the current PC to instruction memory. It guesses that the next PC is the sequential one and records the PC, the guess and its epoch bit in a small in-order queue. Instruction memory returns its responses in request order. Each response is paired with the entry at the head of the queue.

The execute side looks at the head entry when a response is available. If the entry carries the current execute epoch and the datapath raises no hazard stall, the instruction is issued. Its true successor is the sequential PC unless the execute datapath supplies a control target. When that successor differs from the guess, execute redirects the PC register and flips both epoch bits. Fetch sees the redirected PC in the same cycle. Entries fetched on the wrong path keep the old epoch bit, and they are later dropped along with their memory responses. No pipeline register is flushed. A registered one-cycle pulse reports each misprediction.

Top module: `spec_fetch_front`

## Requirements
- R1: While reset is held, the fetch address is RESET_PC (0 by default), the fetch request is valid, and exe_valid, exe_drop and mispredict are low. Both epochs start at 0 and the queue starts empty.
- R2: Each accepted fetch request is followed by one at that address plus PC_STEP (4), unless a redirect occurs. With no acceptance and no redirect, the fetch address holds.
- R3: imem_req_valid is low exactly when the queue holds DEPTH entries. This means fetch stalls when the queue is full, and a pop in the same cycle does not free the slot early.
- R4: When a response is present and the head entry carries the current epoch, exe_valid equals the inverse of exe_stall. exe_pc shows the head PC and exe_inst shows the response word. The response is popped only together with exe_valid or exe_drop.
- R5: The resolved next PC is exe_ctl_target when exe_ctl_valid is high, and exe_pc plus PC_STEP otherwise. A control target equal to the sequential PC is not a misprediction.
- R6: In a cycle where an issued instruction resolves to a next PC that differs from its prediction, imem_req_addr already equals the resolved PC. Later fetches continue sequentially from it.
- R7: When a response is present and the head entry is stale, exe_drop is high, exe_valid is low and the response is popped, regardless of exe_stall. Non-stale heads never raise exe_drop.
- R8: mispredict is high for exactly the one cycle after each redirect.
- R9: exe_stall high forces exe_valid low.
- R10: Entries fetched before a redirect are never issued. The sequence of issued PCs equals the program's architectural path, and the fetch and execute epochs always agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_req_valid | output | 1 | Fetch request valid (queue not full) |
| imem_req_ready | input | 1 | Instruction memory accepts the request |
| imem_req_addr | output | ADDR_W | Fetch address |
| imem_rsp_valid | input | 1 | Oldest outstanding response available |
| imem_rsp_data | input | INST_W | Oldest outstanding response word |
| imem_rsp_pop | output | 1 | Oldest response consumed this cycle |
| exe_stall | input | 1 | Data hazard stall from execute |
| exe_ctl_valid | input | 1 | Execute datapath overrides the next PC |
| exe_ctl_target | input | ADDR_W | Override next PC |
| exe_valid | output | 1 | Head instruction issued this cycle |
| exe_pc | output | ADDR_W | PC of the head entry |
| exe_inst | output | INST_W | Instruction word of the head entry |
| exe_drop | output | 1 | Stale head entry discarded this cycle |
| mispredict | output | 1 | One-cycle pulse after a redirect |

## Verification
The hardest case to reach from the ports is a stale entry at the head while the hazard stall is high. It needs a redirect while other wrong-path requests are still outstanding, and then a stall in the cycle that entry reaches the head. The bench withholds responses for the first cycles so that the queue fills up. It then takes forward jumps every few dozen instructions, which leaves several wrong-path entries behind each redirect. Random stalls and random memory readiness land on those stale heads. The bench's mirror of the queue marks every entry that is outstanding at a redirect as stale, and so it knows which heads must be dropped.

// File: rtl/sff_pkg.sv
package sff_pkg;
  parameter int unsigned ADDR_W  = 32;
  parameter int unsigned INST_W  = 32;
  parameter int unsigned EPOCH_W = 1;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [INST_W-1:0]  inst_t;
  typedef logic [EPOCH_W-1:0] epoch_t;

  typedef struct packed {
    addr_t  pc;
    addr_t  pred;
    epoch_t ep;
  } fq_entry_t;

  localparam int unsigned FQ_ENTRY_W = $bits(fq_entry_t);

  function automatic addr_t seq_pc(input addr_t pc, input addr_t step);
    return pc + step;
  endfunction

  function automatic addr_t resolve_pc(input addr_t pc, input addr_t step,
                                       input logic ovr, input addr_t tgt);
    return ovr ? tgt : seq_pc(pc, step);
  endfunction
endpackage

// File: rtl/sff_fifo.sv
module sff_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sff_pc_reg.sv
module sff_pc_reg
  import sff_pkg::*;
#(
  parameter addr_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  redir_en,
  input  addr_t redir_pc,
  input  logic  adv_en,
  input  addr_t step,
  output addr_t cur_pc
);
  addr_t pc_q;

  // Redirect write is visible to the reader in the same cycle.
  assign cur_pc = redir_en ? redir_pc : pc_q;

  // The fetch advance is applied after the redirect and wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= RESET_PC;
    else if (adv_en)   pc_q <= seq_pc(cur_pc, step);
    else if (redir_en) pc_q <= redir_pc;
  end
endmodule

// File: rtl/sff_epoch_track.sv
module sff_epoch_track
  import sff_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  output epoch_t fetch_ep,
  output epoch_t fetch_ep_rd,
  output epoch_t exec_ep
);
  epoch_t fetch_q, exec_q;

  assign fetch_ep    = fetch_q;
  assign exec_ep     = exec_q;
  assign fetch_ep_rd = advance ? epoch_t'(fetch_q + 1'b1) : fetch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= '0;
      exec_q  <= '0;
    end else if (advance) begin
      fetch_q <= fetch_q + 1'b1;
      exec_q  <= exec_q + 1'b1;
    end
  end
endmodule

// File: rtl/sff_resolve.sv
module sff_resolve
  import sff_pkg::*;
(
  input  addr_t head_pc,
  input  addr_t head_pred,
  input  logic  ctl_valid,
  input  addr_t ctl_target,
  input  addr_t step,
  output addr_t actual_pc,
  output logic  mismatch
);
  assign actual_pc = resolve_pc(head_pc, step, ctl_valid, ctl_target);
  assign mismatch  = (actual_pc != head_pred);
endmodule

// File: rtl/spec_fetch_front.sv
module spec_fetch_front
  import sff_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              imem_req_valid,
  input  logic              imem_req_ready,
  output logic [ADDR_W-1:0] imem_req_addr,
  input  logic              imem_rsp_valid,
  input  logic [INST_W-1:0] imem_rsp_data,
  output logic              imem_rsp_pop,
  input  logic              exe_stall,
  input  logic              exe_ctl_valid,
  input  logic [ADDR_W-1:0] exe_ctl_target,
  output logic              exe_valid,
  output logic [ADDR_W-1:0] exe_pc,
  output logic [INST_W-1:0] exe_inst,
  output logic              exe_drop,
  output logic              mispredict
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam addr_t       STEP  = ADDR_W'(PC_STEP);

  // Named internal events, also observed by the bound checker.
  logic             req_fire;
  logic             redirect;
  logic             head_live;
  logic             head_stale;
  addr_t            actual_pc;
  logic             mismatch;
  addr_t            fetch_pc;
  epoch_t           fetch_ep, fetch_ep_rd, exec_ep;
  logic [CNT_W-1:0] q_count;
  logic             q_full, q_empty;
  fq_entry_t        push_ent, head_ent;
  logic [FQ_ENTRY_W-1:0] head_bits;
  logic             mispredict_q;

  assign head_ent   = fq_entry_t'(head_bits);
  assign head_live  = !q_empty && imem_rsp_valid;
  assign head_stale = (head_ent.ep != exec_ep);

  assign exe_drop     = head_live && head_stale;
  assign exe_valid    = head_live && !head_stale && !exe_stall;
  assign imem_rsp_pop = exe_drop || exe_valid;
  assign redirect     = exe_valid && mismatch;

  assign exe_pc   = head_ent.pc;
  assign exe_inst = imem_rsp_data;

  assign imem_req_valid = !q_full;
  assign imem_req_addr  = fetch_pc;
  assign req_fire       = imem_req_valid && imem_req_ready;

  always_comb begin
    push_ent.pc   = fetch_pc;
    push_ent.pred = seq_pc(fetch_pc, STEP);
    push_ent.ep   = fetch_ep_rd;
  end

  sff_resolve u_resolve (
    .head_pc    (head_ent.pc),
    .head_pred  (head_ent.pred),
    .ctl_valid  (exe_ctl_valid),
    .ctl_target (exe_ctl_target),
    .step       (STEP),
    .actual_pc  (actual_pc),
    .mismatch   (mismatch)
  );

  sff_pc_reg #(.RESET_PC(ADDR_W'(RESET_PC))) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .redir_en (redirect),
    .redir_pc (actual_pc),
    .adv_en   (req_fire),
    .step     (STEP),
    .cur_pc   (fetch_pc)
  );

  sff_epoch_track u_epoch (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (redirect),
    .fetch_ep    (fetch_ep),
    .fetch_ep_rd (fetch_ep_rd),
    .exec_ep     (exec_ep)
  );

  sff_fifo #(.WIDTH(FQ_ENTRY_W), .DEPTH(DEPTH)) u_fq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_fire),
    .push_data (push_ent),
    .pop       (imem_rsp_pop),
    .head      (head_bits),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mispredict_q <= 1'b0;
    else        mispredict_q <= redirect;
  end
  assign mispredict = mispredict_q;
endmodule

// File: rtl/spec_fetch_front_chk.sv
module spec_fetch_front_chk
  import sff_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned PC_STEP = 4,
  parameter int unsigned CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             imem_req_valid,
  input logic             imem_req_ready,
  input addr_t            imem_req_addr,
  input logic             imem_rsp_valid,
  input logic             imem_rsp_pop,
  input logic             exe_valid,
  input logic             exe_stall,
  input logic             exe_drop,
  input logic             mispredict,
  input logic             redirect,
  input addr_t            actual_pc,
  input epoch_t           fetch_ep,
  input epoch_t           exec_ep,
  input logic [CNT_W-1:0] q_count
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(imem_req_valid && imem_req_ready) && !redirect
      |-> imem_req_addr == $past(imem_req_addr) + ADDR_W'(PC_STEP));

  p_seq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !$past(imem_req_valid && imem_req_ready) && !redirect
      |-> $stable(imem_req_addr));

  p_full_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CNT_W'(DEPTH)) |-> !imem_req_valid);

  p_pop_with_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rsp_pop |-> imem_rsp_valid && (q_count != '0));

  p_redirect_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> imem_req_addr == actual_pc);

  p_drop_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exe_drop |-> !exe_valid && imem_rsp_pop);

  p_mispredict_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> mispredict);

  p_mispredict_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && mispredict |-> $past(redirect));

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exe_stall |-> !exe_valid);

  p_epochs_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ep == exec_ep);
endmodule

bind spec_fetch_front spec_fetch_front_chk #(
  .DEPTH   (DEPTH),
  .PC_STEP (PC_STEP),
  .CNT_W   (CNT_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .imem_req_valid (imem_req_valid),
  .imem_req_ready (imem_req_ready),
  .imem_req_addr  (imem_req_addr),
  .imem_rsp_valid (imem_rsp_valid),
  .imem_rsp_pop   (imem_rsp_pop),
  .exe_valid      (exe_valid),
  .exe_stall      (exe_stall),
  .exe_drop       (exe_drop),
  .mispredict     (mispredict),
  .redirect       (redirect),
  .actual_pc      (actual_pc),
  .fetch_ep       (fetch_ep),
  .exec_ep        (exec_ep),
  .q_count        (q_count)
);

// File: tb/spec_fetch_front_tb_top.sv
`timescale 1ns/100ps
module spec_fetch_front_tb_top;
  localparam int unsigned DEPTH  = 4;
  localparam int unsigned NINST  = 400;
  localparam int unsigned WD_CYC = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req_valid, imem_req_ready;
  logic [31:0] imem_req_addr;
  logic        imem_rsp_valid;
  logic [31:0] imem_rsp_data;
  logic        imem_rsp_pop;
  logic        exe_stall, exe_ctl_valid;
  logic [31:0] exe_ctl_target;
  logic        exe_valid;
  logic [31:0] exe_pc, exe_inst;
  logic        exe_drop, mispredict;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  spec_fetch_front #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
    .imem_req_addr(imem_req_addr),
    .imem_rsp_valid(imem_rsp_valid), .imem_rsp_data(imem_rsp_data),
    .imem_rsp_pop(imem_rsp_pop),
    .exe_stall(exe_stall), .exe_ctl_valid(exe_ctl_valid),
    .exe_ctl_target(exe_ctl_target),
    .exe_valid(exe_valid), .exe_pc(exe_pc), .exe_inst(exe_inst),
    .exe_drop(exe_drop), .mispredict(mispredict)
  );

  // Program model: which PCs carry control flow, and where they go.
  function automatic bit is_ctl(input logic [31:0] pc);
    return (pc[6:2] == 5'd7) || (pc[6:2] == 5'd20) || (pc >= 32'h300);
  endfunction
  function automatic logic [31:0] ctl_tgt(input logic [31:0] pc);
    if (pc >= 32'h300)      return 32'h10;
    if (pc[6:2] == 5'd7)    return pc + 32'h24;
    return pc + 32'd4;      // explicit target equal to the sequential PC
  endfunction
  function automatic logic [31:0] arch_next(input logic [31:0] pc);
    return is_ctl(pc) ? ctl_tgt(pc) : pc + 32'd4;
  endfunction
  function automatic logic [31:0] inst_of(input logic [31:0] a);
    return a ^ 32'hC3A5_0000;
  endfunction

  logic [31:0] expq[$];    // scoreboard: architectural PC stream
  logic [31:0] addrq[$];   // mirror of the design's queue
  bit          staleq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build_trace();
    logic [31:0] pc = 32'h0;
    for (int i = 0; i < NINST; i++) begin
      expq.push_back(pc);
      pc = arch_next(pc);
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", expq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] fetch_model;
    bit          mis_prev;
    int          cyc;
    imem_req_ready = 1'b0;
    imem_rsp_valid = 1'b0;
    imem_rsp_data  = '0;
    exe_stall      = 1'b0;
    exe_ctl_valid  = 1'b0;
    exe_ctl_target = '0;
    build_trace();

    // R1: state during reset
    repeat (3) @(negedge clk);
    imem_req_ready = 1'b1;
    #0.5;
    chk(imem_req_addr == 32'h0, "R1 reset fetch addr", imem_req_addr, 32'h0);
    chk(imem_req_valid == 1'b1, "R1 reset req_valid", imem_req_valid, 1);
    chk(exe_valid == 1'b0 && exe_drop == 1'b0, "R1 reset exe", {exe_valid, exe_drop}, 0);
    chk(mispredict == 1'b0, "R1 reset mispredict", mispredict, 0);
    @(negedge clk);
    rst_n = 1'b1;

    fetch_model = 32'h0;
    mis_prev    = 0;
    cyc         = 0;
    while (expq.size() > 0) begin
      bit mis;
      bit fire;
      logic [31:0] act_pc;
      mis = 0;
      act_pc = '0;
      // drive
      imem_req_ready = (cyc < 12) ? 1'b1 : ($urandom_range(0, 9) < 7);
      exe_stall      = (cyc < 12) ? 1'b0 : ($urandom_range(0, 3) == 0);
      imem_rsp_valid = (cyc >= 10) && (addrq.size() > 0) && ($urandom_range(0, 9) < 8);
      imem_rsp_data  = (addrq.size() > 0) ? inst_of(addrq[0]) : 32'h0;
      #0.5;
      exe_ctl_valid  = (addrq.size() > 0) && is_ctl(exe_pc);
      exe_ctl_target = ctl_tgt(exe_pc);
      #0.5;

      // R3: request valid tracks the queue occupancy
      chk(imem_req_valid == (addrq.size() < DEPTH), "R3 full stall",
          imem_req_valid, addrq.size() < DEPTH);

      if (imem_rsp_valid) begin
        if (staleq[0]) begin
          chk(exe_drop && !exe_valid && imem_rsp_pop, "R7 stale dropped",
              {exe_drop, exe_valid, imem_rsp_pop}, 3'b101);
        end else begin
          chk(!exe_drop && (exe_valid == !exe_stall), "R4 issue",
              {exe_drop, exe_valid}, {1'b0, !exe_stall});
          chk(imem_rsp_pop == exe_valid, "R4 pop with issue", imem_rsp_pop, exe_valid);
          chk(exe_pc == addrq[0], "R4 head pc", exe_pc, addrq[0]);
        end
      end else begin
        chk(!exe_valid && !exe_drop && !imem_rsp_pop, "R4 idle",
            {exe_valid, exe_drop, imem_rsp_pop}, 0);
      end
      if (exe_stall) chk(!exe_valid, "R9 stall blocks issue", exe_valid, 0);

      if (exe_valid) begin
        logic [31:0] want;
        want = expq.pop_front();
        chk(exe_pc == want, "R10 architectural path", exe_pc, want);
        chk(exe_inst == inst_of(exe_pc), "R4 instruction word", exe_inst, inst_of(exe_pc));
        act_pc = exe_ctl_valid ? exe_ctl_target : exe_pc + 32'd4;   // R5
        mis = (act_pc != exe_pc + 32'd4);
        if (mis) chk(imem_req_addr == act_pc, "R6 same-cycle redirect", imem_req_addr, act_pc);
        else if (exe_ctl_valid) chk(imem_req_addr == fetch_model, "R5 no redirect on equal target",
                                    imem_req_addr, fetch_model);
      end

      chk(mispredict == mis_prev, "R8 mispredict pulse", mispredict, mis_prev);

      if (mis) fetch_model = act_pc;
      fire = imem_req_valid && imem_req_ready;
      if (fire) chk(imem_req_addr == fetch_model, "R2 fetch address", imem_req_addr, fetch_model);

      if (imem_rsp_pop && addrq.size() > 0) begin
        void'(addrq.pop_front());
        void'(staleq.pop_front());
      end
      if (mis) foreach (staleq[i]) staleq[i] = 1'b1;
      if (fire) begin
        addrq.push_back(imem_req_addr);
        staleq.push_back(1'b0);
        fetch_model = imem_req_addr + 32'd4;
      end
      mis_prev = mis;
      cyc++;
      @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule